// File: doc/BRIEF.md
# Burst-Mode Transceiver Power Sequencer

This block sequences the power enables of a half-duplex transceiver front end from two asynchronous burst strobes, a transmit strobe and a receive strobe. Both strobes are resynchronised into the transmit clock domain before their edges are detected, and every output is registered in that domain.

When a transmit burst starts, the transmit path powers up without any programmed delay. When the burst ends, the block issues a one-cycle flush strobe and holds a midscale-insert flag for a fixed window, so the interpolation filter drains on midscale data. The transmit path powers down only after both that window and a programmable delay have elapsed. The receive path follows either the transmit strobe in inverted sense or the receive strobe directly, as selected by configuration. Two enable bits, one per path, let software keep either path permanently powered.

Configuration is captured from a parallel input on a write strobe into a small internal register that resets to its defaults.

Top module: `burst_pwr_seq`

## Requirements
- R1: After reset the transmit enable is low, the receive enable is high, and the flush strobe and midscale flag are both low.
- R2: A rising transmit strobe driven between clock edges shows as a high transmit enable after the third following rising clock edge, with no programmed delay.
- R3: A falling transmit strobe gives a flush strobe high for exactly one cycle and a midscale flag high for exactly 33 cycles, both starting after the third following rising edge.
- R4: The transmit enable falls one cycle after the midscale flag falls (after the 37th rising edge following the falling strobe), whatever the value (0 to 31) in the power-down delay field.
- R5: A rising transmit strobe while a power-down is pending keeps the transmit enable high and clears the midscale flag and both counters, after the third following rising edge.
- R6: With the receive source select at 0 (transmit strobe), a falling transmit strobe raises the receive enable and a rising one lowers it, after the third following rising edge.
- R7: With the receive source select at 1 (receive strobe), a rising receive strobe raises the receive enable and a falling one lowers it, after the third following rising edge; transmit strobe edges then leave the receive enable unchanged.
- R8: With the transmit fast power-down enable at 0, the transmit enable stays high through idle time and through a complete burst end.
- R9: With the receive fast power-down enable at 0, the receive enable stays high while the selected strobe calls for power-down.
- R10: A write strobe high at a rising edge loads all four configuration fields at that edge; the reset values are delay 31, source select 0, both enables 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txen_i | input | 1 | Asynchronous transmit burst strobe |
| rxen_i | input | 1 | Asynchronous receive burst strobe |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_pd_delay | input | 5 | Transmit power-down delay, 0 to 31 cycles |
| cfg_rx_src | input | 1 | Receive control source: 0 transmit strobe, 1 receive strobe |
| cfg_tx_fpd_en | input | 1 | Transmit fast power-down enable |
| cfg_rx_fpd_en | input | 1 | Receive fast power-down enable |
| tx_power_on | output | 1 | Transmit path power enable |
| rx_power_on | output | 1 | Receive path power enable |
| flush_strobe | output | 1 | One-cycle request to start the filter flush |
| midscale_insert | output | 1 | High while midscale samples are fed to the filter |

## Verification
The flush window and a fresh burst start can land in the same cycle: a rising transmit strobe that arrives ten cycles into the midscale window must win over the pending power-down. The bench provokes this by raising the strobe mid-flush and judges it by the midscale flag dropping after the third edge while the transmit enable stays high well past the point where the abandoned power-down would have fired. The same burst end is also replayed with delay 0 and delay 31 to show that power-down timing is set by the longer of the two windows.

// File: rtl/burst_pwr_pkg.sv
// Shared types for the burst power sequencer.
// Assumes the delay field width is fixed at five bits for the whole block.
package burst_pwr_pkg;

    localparam int PD_DLY_W = 5;

    typedef enum logic {
        RX_SRC_TXEN = 1'b0,
        RX_SRC_RXEN = 1'b1
    } rx_src_e;

    typedef struct packed {
        logic [PD_DLY_W-1:0] pd_delay;
        rx_src_e             rx_src;
        logic                tx_fpd_en;
        logic                rx_fpd_en;
    } pwr_cfg_t;

endpackage

// File: rtl/strobe_sync.sv
// Resynchronises N asynchronous strobes and flags their edges.
// Assumes strobes are held for at least two clock cycles between changes.
// Edge flags are combinational from the synchroniser's last two stages.
module strobe_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    for (genvar g = 0; g < N; g++) begin : g_lane
        logic [STAGES:0] chain;

        // Shift the strobe through the synchroniser plus one history stage.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-1:0], async_i[g]};
        end

        assign rise_o[g] =  chain[STAGES-1] & ~chain[STAGES];
        assign fall_o[g] = ~chain[STAGES-1] &  chain[STAGES];
    end

endmodule

// File: rtl/tx_pd_seq.sv
// Transmit power sequencer: powers up on a burst start, and on a burst end
// runs a midscale flush window and a programmable delay in parallel,
// powering down once both are over. A new burst start cancels the shutdown.
// Assumes edge inputs are single-cycle pulses in this clock domain.
module tx_pd_seq #(
    parameter int DLY_W     = 5,
    parameter int FLUSH_LEN = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_rise,
    input  logic             tx_fall,
    input  logic [DLY_W-1:0] pd_delay,
    output logic             tx_on,
    output logic             flush_strobe,
    output logic             midscale
);

    localparam int FCNT_W = $clog2(FLUSH_LEN);
    localparam logic [FCNT_W-1:0] FLUSH_LAST = FCNT_W'(FLUSH_LEN - 1);
    localparam logic [DLY_W-1:0]  DLY_MAX    = '1;

    logic              pending;
    logic [FCNT_W-1:0] fcnt;
    logic [DLY_W-1:0]  dcnt;
    logic              delay_done;

    assign delay_done = (dcnt >= pd_delay);

    // Power state and pending shutdown; a burst start outranks everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_on   <= 1'b0;
            pending <= 1'b0;
        end else if (tx_rise) begin
            tx_on   <= 1'b1;
            pending <= 1'b0;
        end else if (tx_fall) begin
            pending <= 1'b1;
        end else if (pending && !midscale && delay_done) begin
            tx_on   <= 1'b0;
            pending <= 1'b0;
        end
    end

    // Flush window: one-cycle strobe and a FLUSH_LEN-cycle midscale flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            midscale     <= 1'b0;
            flush_strobe <= 1'b0;
            fcnt         <= '0;
        end else if (tx_rise) begin
            midscale     <= 1'b0;
            flush_strobe <= 1'b0;
            fcnt         <= '0;
        end else if (tx_fall) begin
            midscale     <= 1'b1;
            flush_strobe <= 1'b1;
            fcnt         <= '0;
        end else begin
            flush_strobe <= 1'b0;
            if (midscale) begin
                if (fcnt == FLUSH_LAST) midscale <= 1'b0;
                else                    fcnt <= fcnt + 1'b1;
            end
        end
    end

    // Power-down delay counter, saturating at its maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)                     dcnt <= '0;
        else if (tx_rise || tx_fall)    dcnt <= '0;
        else if (pending && dcnt != DLY_MAX) dcnt <= dcnt + 1'b1;
    end

    p_up_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rise |=> tx_on);

    p_flush_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (midscale && fcnt != FLUSH_LAST && !tx_rise) |=> midscale);

    p_power_in_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
        midscale |-> tx_on);

    p_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && tx_rise) |=> (tx_on && !midscale && !pending));

endmodule

// File: rtl/rx_pwr_ctl.sv
// Receive power control: follows the transmit strobe inverted or the
// receive strobe directly, chosen by the source select.
// Assumes edge inputs are single-cycle pulses in this clock domain.
module rx_pwr_ctl
    import burst_pwr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  rx_src_e src,
    input  logic    tx_rise,
    input  logic    tx_fall,
    input  logic    rx_rise,
    input  logic    rx_fall,
    output logic    rx_on
);

    logic go_up;
    logic go_down;

    // Pick the edge pair that drives the receive power state.
    always_comb begin
        if (src == RX_SRC_TXEN) begin
            go_up   = tx_fall;
            go_down = tx_rise;
        end else begin
            go_up   = rx_rise;
            go_down = rx_fall;
        end
    end

    // Receive power state, powered at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_on <= 1'b1;
        else if (go_up)   rx_on <= 1'b1;
        else if (go_down) rx_on <= 1'b0;
    end

    p_txsrc_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (src == RX_SRC_TXEN && tx_fall) |=> rx_on);

    p_rxsrc_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (src == RX_SRC_RXEN && rx_fall && !rx_rise) |=> !rx_on);

endmodule

// File: rtl/burst_pwr_seq.sv
// Top of the burst power sequencer: configuration register, strobe
// synchroniser, transmit sequencer and receive control.
// Assumes everything runs on the transmit clock with synchronous reset.
module burst_pwr_seq
    import burst_pwr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FLUSH_LEN   = 33
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                txen_i,
    input  logic                rxen_i,
    input  logic                cfg_we,
    input  logic [PD_DLY_W-1:0] cfg_pd_delay,
    input  logic                cfg_rx_src,
    input  logic                cfg_tx_fpd_en,
    input  logic                cfg_rx_fpd_en,
    output logic                tx_power_on,
    output logic                rx_power_on,
    output logic                flush_strobe,
    output logic                midscale_insert
);

    localparam pwr_cfg_t CFG_RESET = '{
        pd_delay:  '1,
        rx_src:    RX_SRC_TXEN,
        tx_fpd_en: 1'b1,
        rx_fpd_en: 1'b1
    };

    pwr_cfg_t   cfg_q;
    logic [1:0] rise;
    logic [1:0] fall;
    logic       tx_on;
    logic       rx_on;

    // Configuration register, loaded on the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else if (cfg_we) begin
            cfg_q.pd_delay  <= cfg_pd_delay;
            cfg_q.rx_src    <= rx_src_e'(cfg_rx_src);
            cfg_q.tx_fpd_en <= cfg_tx_fpd_en;
            cfg_q.rx_fpd_en <= cfg_rx_fpd_en;
        end
    end

    strobe_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({rxen_i, txen_i}),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    tx_pd_seq #(.DLY_W(PD_DLY_W), .FLUSH_LEN(FLUSH_LEN)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_rise      (rise[0]),
        .tx_fall      (fall[0]),
        .pd_delay     (cfg_q.pd_delay),
        .tx_on        (tx_on),
        .flush_strobe (flush_strobe),
        .midscale     (midscale_insert)
    );

    rx_pwr_ctl u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (cfg_q.rx_src),
        .tx_rise (rise[0]),
        .tx_fall (fall[0]),
        .rx_rise (rise[1]),
        .rx_fall (fall[1]),
        .rx_on   (rx_on)
    );

    assign tx_power_on = tx_on | ~cfg_q.tx_fpd_en;
    assign rx_power_on = rx_on | ~cfg_q.rx_fpd_en;

    p_flush_starts_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_strobe |-> midscale_insert);

    p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_rx_fpd_en) |=> rx_power_on);

endmodule

// File: tb/burst_pwr_seq_bench.sv
`timescale 1ns/1ps
module burst_pwr_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txen = 1'b0;
    logic       rxen = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_dly = 5'd31;
    logic       cfg_src = 1'b0;
    logic       cfg_txe = 1'b1;
    logic       cfg_rxe = 1'b1;
    logic       tx_pwr, rx_pwr, fstb, mid;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    typedef struct {
        int    at;
        int    sig;   // 0 tx, 1 rx, 2 midscale, 3 flush strobe
        bit    val;
        string req;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    burst_pwr_seq u_burst_pwr_seq (
        .clk(clk), .rst_n(rst_n), .txen_i(txen), .rxen_i(rxen),
        .cfg_we(cfg_we), .cfg_pd_delay(cfg_dly), .cfg_rx_src(cfg_src),
        .cfg_tx_fpd_en(cfg_txe), .cfg_rx_fpd_en(cfg_rxe),
        .tx_power_on(tx_pwr), .rx_power_on(rx_pwr),
        .flush_strobe(fstb), .midscale_insert(mid)
    );

    function automatic bit sig_val(int s);
        case (s)
            0: return tx_pwr;
            1: return rx_pwr;
            2: return mid;
            default: return fstb;
        endcase
    endfunction

    task automatic check(bit act, bit exp, string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", req, cyc, act, exp);
        end
    endtask

    task automatic push(int at, int sig, bit val, string req);
        exp_t e;
        e.at = at; e.sig = sig; e.val = val; e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: compare every scoreboard item due in this cycle.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                check(sig_val(sb[i].sig), sb[i].val, sb[i].req);
                sb.delete(i);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(bit [4:0] d, bit s, bit te, bit re);
        cfg_dly = d; cfg_src = s; cfg_txe = te; cfg_rxe = re; cfg_we = 1'b1;
        step(1);
        cfg_we = 1'b0;
    endtask

    // Driver: one full transmit burst with its expected outputs.
    task automatic tx_burst(bit rx_follows);
        int c;
        c = cyc;
        txen = 1'b1;
        push(c + 2, 0, 1'b0, "R2"); push(c + 3, 0, 1'b1, "R2");
        if (rx_follows) begin
            push(c + 2, 1, 1'b1, "R6"); push(c + 3, 1, 1'b0, "R6");
        end
        step(10);
        c = cyc;
        txen = 1'b0;
        push(c + 2, 3, 1'b0, "R3"); push(c + 3, 3, 1'b1, "R3"); push(c + 4, 3, 1'b0, "R3");
        push(c + 2, 2, 1'b0, "R3"); push(c + 3, 2, 1'b1, "R3");
        push(c + 35, 2, 1'b1, "R3"); push(c + 36, 2, 1'b0, "R3");
        push(c + 36, 0, 1'b1, "R4"); push(c + 37, 0, 1'b0, "R4");
        if (rx_follows) begin
            push(c + 2, 1, 1'b0, "R6"); push(c + 3, 1, 1'b1, "R6");
        end
        step(45);
    endtask

    initial begin
        int c;
        step(4);
        rst_n = 1'b1;
        step(1);
        check(tx_pwr, 1'b0, "R1 tx off");
        check(rx_pwr, 1'b1, "R1 rx on");
        check(mid, 1'b0, "R1 midscale");
        check(fstb, 1'b0, "R1 strobe");

        // Default config (R10): delay 31, transmit strobe as receive source.
        tx_burst(1'b1);

        // Delay 0: same power-down cycle (R4), new config loaded (R10).
        cfg_write(5'd0, 1'b0, 1'b1, 1'b1);
        tx_burst(1'b1);

        // Burst restart in the middle of the flush (R5).
        txen = 1'b1;
        step(10);
        c = cyc;
        txen = 1'b0;
        step(12);
        c = cyc;
        txen = 1'b1;
        push(c + 2, 2, 1'b1, "R5"); push(c + 3, 2, 1'b0, "R5");
        push(c + 3, 0, 1'b1, "R5"); push(c + 40, 0, 1'b1, "R5");
        step(45);
        txen = 1'b0;
        step(45);

        // Receive strobe as source (R7), config load (R10).
        c = cyc;
        cfg_write(5'd31, 1'b1, 1'b1, 1'b1);
        rxen = 1'b1;
        step(6);
        c = cyc;
        rxen = 1'b0;
        push(c + 2, 1, 1'b1, "R7"); push(c + 3, 1, 1'b0, "R7");
        step(6);
        c = cyc;
        txen = 1'b1;
        step(8);
        txen = 1'b0;
        push(c + 20, 1, 1'b0, "R7 tx edges ignored");
        step(45);
        c = cyc;
        rxen = 1'b1;
        push(c + 2, 1, 1'b0, "R7"); push(c + 3, 1, 1'b1, "R7");
        step(6);
        rxen = 1'b0;
        step(6);

        // Fast power-down disables (R8, R9).
        c = cyc;
        cfg_write(5'd31, 1'b1, 1'b0, 1'b0);
        push(c + 1, 0, 1'b1, "R8 idle"); push(c + 1, 1, 1'b1, "R9");
        step(3);
        c = cyc;
        txen = 1'b1;
        step(10);
        txen = 1'b0;
        push(c + 60, 0, 1'b1, "R8 after burst");
        push(c + 60, 1, 1'b1, "R9 held");
        step(70);

        if (sb.size() != 0) begin
            failures += sb.size();
            $display("FAIL scoreboard: actual=%0d pending expected=0", sb.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog.
    initial begin
        #(5ns * 20000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule